// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the settings of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divider code and a 3-bit test-select code. The settings can be written in two ways. In the first, a group of dedicated pins is used directly. In the second, a three-wire serial link carries a serial clock, serial data and a load strobe. An active-low mode pin chooses between the two. The block drives the active divide, divider-code and test-select values, along with the bit that leaves the end of its shift register.

All pins arrive without timing relative to the system clock. Each pin passes through a synchronizer of `SYNC_STAGES` flops. Edges on the serial clock and on the load strobe are found by edge detection in the system clock domain. The serial clock must therefore stay at each level for several system clock cycles. The analog synthesizer, which uses these values, lies outside this block.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high, and after it is released with `par_load_n` high and no serial activity, `m_out` is all ones (511), `n_out` is 2'b11, `t_out` is 3'b000 and `shift_out` is 0.
- R2: While `par_load_n` is low, `m_out` and `n_out` follow `m_pins` and `n_pins` after the synchronizer delay, for any pin value.
- R3: While `par_load_n` is low, `t_out` is 3'b000.
- R4: After `par_load_n` rises, `m_out` and `n_out` keep the pin values present just before the edge. Later changes on `m_pins` and `n_pins` have no effect until the mode pin goes low again.
- R5: While `par_load_n` is high, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 14-bit register. `shift_out` is bit 13 of that register, which is the bit shifted in 14 edges earlier, and is 0 after reset.
- R6: A serial frame is sent with the first-sent bit first: T2, T1, T0, N1, N0, M8 ... M0. On the rising edge of `ser_load` with `par_load_n` high, `t_out`, `n_out` and `m_out` take bits [13:11], [10:9] and [8:0] of the register.
- R7: After `ser_load` falls, further serial clock edges shift the register but leave `m_out`, `n_out` and `t_out` unchanged.
- R8: While `ser_load` is held high, each `ser_clk` rising edge loads `m_out` with the low 9 bits of the register after that shift, so that `ser_data` becomes M0. `n_out` and `t_out` do not change.
- R9: `ser_clk` edges seen while `par_load_n` is low do not shift the register. This is visible through `shift_out` and through a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Low: parallel pins drive the settings; high: serial mode |
| m_pins | input | 9 | Parallel feedback divide value |
| n_pins | input | 2 | Parallel output divider code |
| ser_clk | input | 1 | Serial shift clock, sampled in `clk` domain |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial transfer/latch strobe |
| m_out | output | 9 | Active feedback divide value |
| n_out | output | 2 | Active output divider code |
| t_out | output | 3 | Active test-select code |
| shift_out | output | 1 | Oldest bit of the shift register |

## Verification
The bench sweeps the parallel pins over a spread of divide values and all four divider codes. It then checks that a rising mode pin freezes the values. A design that latched on the wrong edge, or let the pins pass through, would show the new pin value. Serial frames with distinct T, N and M fields are shifted in, with `shift_out` checked after every bit. A reversed bit order or a misplaced field boundary would swap or shift fields after the transfer. The bench also covers clock edges that arrive after the strobe falls and edges that arrive while the strobe is held high. Clock edges sent in parallel mode must leave the register as it was, or a later transfer reveals the extra shifts.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    LD_PARALLEL,
    LD_TRANSFER,
    LD_FOLLOW,
    LD_HOLD
  } load_mode_e;
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  genvar i;
  generate
    for (i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
`timescale 1ns/1ps
module cfg_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shift.sv
`timescale 1ns/1ps
module cfg_shift #(
  parameter int FW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          din,
  output logic [FW-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst)     sr_q <= '0;
    else if (en) sr_q <= {sr_q[FW-2:0], din};
  end
endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
module cfg_regs
  import cfg_loader_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  localparam int FW = T_W + N_W + M_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pl_s,
  input  logic           sld_s,
  input  logic           sld_rise,
  input  logic           sclk_rise,
  input  logic           sd_s,
  input  logic [M_W-1:0] mp_s,
  input  logic [N_W-1:0] np_s,
  input  logic [FW-1:0]  sr_q,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q
);
  load_mode_e mode;

  always_comb begin
    if (!pl_s)                   mode = LD_PARALLEL;
    else if (sld_rise)           mode = LD_TRANSFER;
    else if (sld_s && sclk_rise) mode = LD_FOLLOW;
    else                         mode = LD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '1;
      n_q <= '1;
      t_q <= '0;
    end else begin
      case (mode)
        LD_PARALLEL: begin
          m_q <= mp_s;
          n_q <= np_s;
          t_q <= '0;
        end
        LD_TRANSFER: begin
          t_q <= sr_q[FW-1 -: T_W];
          n_q <= sr_q[M_W +: N_W];
          m_q <= sr_q[M_W-1:0];
        end
        LD_FOLLOW: m_q <= {sr_q[M_W-2:0], sd_s};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] m_pins,
  input  logic [N_W-1:0] n_pins,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] t_out,
  output logic           shift_out
);
  localparam int FW = T_W + N_W + M_W;
  localparam int PW = M_W + N_W;

  logic           pl_s, sclk_s, sd_s, sld_s;
  logic           sclk_rise, sld_rise;
  logic [M_W-1:0] mp_s;
  logic [N_W-1:0] np_s;
  logic [FW-1:0]  sr_q;

  cfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({par_load_n, ser_clk, ser_data, ser_load}),
    .q({pl_s, sclk_s, sd_s, sld_s})
  );

  cfg_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_par (
    .clk(clk), .rst(rst),
    .d({m_pins, n_pins}),
    .q({mp_s, np_s})
  );

  cfg_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst),
    .lvl({sclk_s, sld_s}),
    .rise({sclk_rise, sld_rise})
  );

  cfg_shift #(.FW(FW)) u_shift (
    .clk(clk), .rst(rst),
    .en(pl_s & sclk_rise),
    .din(sd_s),
    .sr_q(sr_q)
  );

  cfg_regs #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_regs (
    .clk(clk), .rst(rst),
    .pl_s(pl_s), .sld_s(sld_s), .sld_rise(sld_rise), .sclk_rise(sclk_rise),
    .sd_s(sd_s), .mp_s(mp_s), .np_s(np_s), .sr_q(sr_q),
    .m_q(m_out), .n_q(n_out), .t_q(t_out)
  );

  assign shift_out = sr_q[FW-1];
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk #(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3,
  parameter int FW = 14
) (
  input logic           clk,
  input logic           rst,
  input logic           pl_s,
  input logic           sld_s,
  input logic           sd_s,
  input logic           sclk_rise,
  input logic           sld_rise,
  input logic [M_W-1:0] mp_s,
  input logic [N_W-1:0] np_s,
  input logic [FW-1:0]  sr_q,
  input logic [M_W-1:0] m_out,
  input logic [N_W-1:0] n_out,
  input logic [T_W-1:0] t_out
);
  assert_par_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (m_out == $past(mp_s) && n_out == $past(np_s)));

  assert_test_clear_R3: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> t_out == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sclk_rise && !sld_rise) |=>
      ($stable(m_out) && $stable(n_out) && $stable(t_out)));

  assert_transfer_R6: assert property (@(posedge clk) disable iff (rst)
    (pl_s && sld_rise) |=> ({t_out, n_out, m_out} == $past(sr_q)));

  assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (pl_s && sld_s && sclk_rise && !sld_rise) |=>
      (m_out == {$past(sr_q[M_W-2:0]), $past(sd_s)} && $stable(n_out) && $stable(t_out)));
endmodule

bind cfg_loader cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .pl_s(pl_s), .sld_s(sld_s), .sd_s(sd_s),
  .sclk_rise(sclk_rise), .sld_rise(sld_rise), .mp_s(mp_s), .np_s(np_s),
  .sr_q(sr_q), .m_out(m_out), .n_out(n_out), .t_out(t_out)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  logic       clk = 0;
  logic       rst = 1;
  logic       par_load_n = 1;
  logic [8:0] m_pins = '0;
  logic [1:0] n_pins = '0;
  logic       ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [8:0] m_out;
  logic [1:0] n_out;
  logic [2:0] t_out;
  logic       shift_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [13:0] sr_e = '0;
  logic [8:0]  m_e;
  logic [1:0]  n_e;
  logic [2:0]  t_e;

  always #10 clk = ~clk;

  cfg_loader u_cfg_loader (
    .clk(clk), .rst(rst), .par_load_n(par_load_n), .m_pins(m_pins), .n_pins(n_pins),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_out(n_out), .t_out(t_out), .shift_out(shift_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sclk_pulse(input bit d);
    ser_data = d;
    wait_n(6);
    ser_clk = 1;
    if (par_load_n) sr_e = {sr_e[12:0], d};
    wait_n(6);
    ser_clk = 0;
    wait_n(6);
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " m"}, m_out, m_e);
    chk({tag, " n"}, n_out, n_e);
    chk({tag, " t"}, t_out, t_e);
  endtask

  initial begin
    wait_n(4);
    m_e = 9'h1FF; n_e = 2'b11; t_e = 3'b000;
    chk_all("R1 in reset");
    chk("R1 shift_out", shift_out, 0);
    rst = 0;
    wait_n(8);
    chk_all("R1 after release");

    // R2/R3 parallel sweep
    par_load_n = 0;
    for (int m = 0; m < 512; m += 37) begin
      for (int n = 0; n < 4; n++) begin
        m_pins = m[8:0]; n_pins = n[1:0];
        wait_n(6);
        chk("R2 m", m_out, m);
        chk("R2 n", n_out, n);
        chk("R3 t", t_out, 0);
      end
    end
    m_pins = 9'h1FF; n_pins = 2'b01; wait_n(6);
    chk("R2 m max", m_out, 511);

    // R4 latch on rising mode pin
    m_pins = 9'd100; n_pins = 2'b10; wait_n(6);
    par_load_n = 1; wait_n(6);
    m_pins = 9'd350; n_pins = 2'b01; wait_n(6);
    chk("R4 m held", m_out, 100);
    chk("R4 n held", n_out, 2);
    m_e = 9'd100; n_e = 2'b10; t_e = 3'b000;

    // R5/R6/R7 serial frames
    for (int f = 0; f < 6; f++) begin
      logic [13:0] frame;
      frame = {3'((f * 3 + 5) % 8), 2'(f % 4), 9'((f * 97 + 100) % 512)};
      for (int b = 13; b >= 0; b--) begin
        sclk_pulse(frame[b]);
        chk("R5 shift_out", shift_out, sr_e[13]);
      end
      chk("R7 no change before strobe m", m_out, m_e);
      ser_load = 1; wait_n(6);
      t_e = frame[13:11]; n_e = frame[10:9]; m_e = frame[8:0];
      chk_all("R6 transfer");
      ser_load = 0; wait_n(6);
      for (int k = 0; k < 3; k++) sclk_pulse(k[0]);
      chk_all("R7 after latch");
    end

    // R8 strobe held high
    ser_load = 1; wait_n(6);
    t_e = sr_e[13:11]; n_e = sr_e[10:9]; m_e = sr_e[8:0];
    chk_all("R8 transfer");
    for (int k = 0; k < 10; k++) begin
      sclk_pulse(((k * 5) % 3) == 1);
      m_e = sr_e[8:0];
      chk_all("R8 follow");
    end
    ser_load = 0; wait_n(6);

    // R9 serial clocks ignored in parallel mode
    par_load_n = 0; m_pins = 9'd200; n_pins = 2'b00; wait_n(6);
    chk("R3 t parallel again", t_out, 0);
    for (int k = 0; k < 5; k++) sclk_pulse(~sr_e[13]);
    par_load_n = 1; wait_n(6);
    chk("R9 shift_out", shift_out, sr_e[13]);
    ser_load = 1; wait_n(6);
    t_e = sr_e[13:11]; n_e = sr_e[10:9]; m_e = sr_e[8:0];
    chk_all("R9 transfer");
    ser_load = 0; wait_n(6);

    // R1 reset mid-run
    rst = 1; wait_n(3);
    m_e = 9'h1FF; n_e = 2'b11; t_e = 3'b000;
    chk_all("R1 second reset");
    chk("R1 shift_out cleared", shift_out, 0);
    rst = 0; wait_n(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule